// File: doc/BRIEF.md
# Up-Counting Timer with PWM Output

This block is a general-purpose timer built around a wide up-counter that runs on the functional clock. A host programs it through a small synchronous register port. One control register sets how it counts: start and stop, reload on wrap, an optional power-of-two prescaler and an optional compare against a match value. It also sets how the single PWM pin behaves. The counter can be read and written directly. A load register supplies the reload value, and writing any data to the trigger address copies the load value into the counter.

Two events come out of the counting logic: overflow, on a count tick from the all-ones value, and match, on a count tick while compare is enabled and the counter equals the match register. Each event sets a sticky status flag, which the host clears by writing 1 to it. A level interrupt is raised while any flag is set and also enabled. The same events can drive the PWM pin. In pulse mode the pin leaves its idle level for one cycle per event. In toggle mode it flips on each event.

There is no streaming data path. The register port, the PWM pin and the interrupt are plain signals with no handshake. A write is taken in the cycle where `reg_wr_en` is high, and read data is a combinational function of `reg_addr`.

Top module: `uptimer_pwm`

## Requirements
- R1: After reset every register reads 0, `pwm_out` is 0 and `irq` is 0.
- R2: Control bit 0 is the run bit. While it is set, the counter grows by one on each count tick. While it is clear, the counter holds its value unless the host writes it.
- R3: Control bit 5 enables the prescaler, and control bits 4:2 hold a ratio r. When enabled, a count tick comes once every 2^(r+1) clocks, with the phase restarting from zero when run or the prescaler enable goes low. When disabled, every clock while running is a tick.
- R4: With control bit 1 clear, a tick at the all-ones value wraps the counter to 0, sets status bit 1 and clears the run bit. A control write in that same cycle takes precedence.
- R5: With control bit 1 set, a tick at the all-ones value loads the counter from the load register, sets status bit 1 and leaves the run bit set.
- R6: With control bit 6 set, a tick while the counter equals the match register sets status bit 0. With bit 6 clear, no match flag is raised.
- R7: A write to the trigger address (3), whatever its data, loads the counter from the load register at that clock edge. A write to the counter address (1) sets the counter to the written data. Both take precedence over counting.
- R8: Status flags are sticky. Writing 1 to a status bit clears it, writing 0 leaves it unchanged, and an event in the same cycle as the clear keeps the flag set.
- R9: `irq` is high exactly when some status bit is set together with the same bit of the interrupt-enable register (bit 0 match, bit 1 overflow).
- R10: Control bit 7 is the PWM idle level. Control bits 11:10 pick the driving events: 00 none, 01 overflow, 10 and 11 overflow or match. With 00, `pwm_out` equals the idle level.
- R11: In pulse mode (control bit 12 clear), `pwm_out` is the inverse of the idle level for exactly the one cycle after each selected event.
- R12: In toggle mode (control bit 12 set), the PWM state inverts after each selected event. The state returns to idle when bits 11:10 are 00.
- R13: The register addresses are 0 control (only bits 0 to 7 and 10 to 12 stored), 1 counter, 2 load, 3 trigger (reads 0), 4 match, 5 interrupt enable (2 bits), and 6 status (2 bits).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Functional clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address for reads and writes |
| reg_wdata | input | CNT_W | Write data |
| reg_rdata | output | CNT_W | Read data for `reg_addr` |
| pwm_out | output | 1 | PWM output pin |
| irq | output | 1 | Level interrupt |

## Verification
The hardest situation to reach is an overflow of the full-width counter that coincides with a match, a prescaled tick or a host write to status or control in the same cycle, since counting up from zero would take billions of cycles. The stimulus therefore writes the counter to within a few steps of all-ones and biases the match value to just ahead of the current count. It keeps prescaler ratios small and mixes these writes randomly with idle cycles, so that overflow, match, reload and clear collide often. Directed sequences pin down exact pulse and toggle timing on the PWM pin.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

  localparam int RATIO_W  = 3;
  localparam int CTRL_W   = 13;
  localparam int EV_N     = 2;
  localparam int EV_MATCH = 0;
  localparam int EV_OVF   = 1;

  // Only these control bits are stored; the rest read back as zero.
  localparam logic [CTRL_W-1:0] CTRL_MASK = 13'h1CFF;

  typedef enum logic [2:0] {
    A_CTRL  = 3'd0,
    A_CNT   = 3'd1,
    A_LOAD  = 3'd2,
    A_TRIG  = 3'd3,
    A_MATCH = 3'd4,
    A_IEN   = 3'd5,
    A_STAT  = 3'd6
  } reg_sel_e;

  // Field layout follows the control register bit positions, MSB first.
  typedef struct packed {
    logic               tgl;
    logic [1:0]         src;
    logic [1:0]         pad;
    logic               idle;
    logic               cmp_en;
    logic               pre_en;
    logic [RATIO_W-1:0] ratio;
    logic               autoreload;
    logic               run;
  } ctrl_t;

endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
  parameter int RATIO_W = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               run,
  input  logic               pre_en,
  input  logic [RATIO_W-1:0] ratio,
  output logic               tick
);
  localparam int PRE_W = 2 ** RATIO_W;

  logic [PRE_W-1:0] phase_q;
  logic [PRE_W:0]   span;
  logic [PRE_W-1:0] last;
  logic             at_last;

  // Period 2^(ratio+1); last phase index is period-1.
  always_comb begin
    span    = {{PRE_W{1'b0}}, 1'b1} << ({1'b0, ratio} + 1'b1);
    last    = PRE_W'(span - 1'b1);
    at_last = (phase_q == last);
  end

  assign tick = run & (~pre_en | at_last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= '0;
    end else if (!run || !pre_en) begin
      phase_q <= '0;
    end else if (at_last) begin
      phase_q <= '0;
    end else begin
      phase_q <= phase_q + 1'b1;
    end
  end

endmodule

// File: rtl/tmr_core.sv
module tmr_core #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             autoreload,
  input  logic             cmp_en,
  input  logic [CNT_W-1:0] load_val,
  input  logic [CNT_W-1:0] match_val,
  input  logic             host_cnt_we,
  input  logic             host_trig_we,
  input  logic [CNT_W-1:0] host_data,
  output logic [CNT_W-1:0] cnt,
  output logic             ovf_ev,
  output logic             mat_ev
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic [CNT_W-1:0] wrap_val;

  assign ovf_ev   = tick & (cnt_q == CNT_MAX);
  assign mat_ev   = tick & cmp_en & (cnt_q == match_val);
  assign wrap_val = autoreload ? load_val : '0;

  always_comb begin
    cnt_d = cnt_q;
    if (host_cnt_we) begin
      cnt_d = host_data;
    end else if (host_trig_we) begin
      cnt_d = load_val;
    end else if (tick) begin
      cnt_d = ovf_ev ? wrap_val : cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign cnt = cnt_q;

endmodule

// File: rtl/tmr_pwm.sv
module tmr_pwm (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       idle_lvl,
  input  logic       toggle_mode,
  input  logic [1:0] src,
  input  logic       ovf_ev,
  input  logic       mat_ev,
  output logic       pwm_out
);
  logic armed;
  logic hit;
  logic pulse_q;
  logic tog_q;

  // src: 00 none, 01 overflow, 1x overflow or match
  assign armed = |src;
  assign hit   = (armed & ovf_ev) | (src[1] & mat_ev);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pulse_q <= 1'b0;
      tog_q   <= 1'b0;
    end else begin
      pulse_q <= hit;
      tog_q   <= armed ? (tog_q ^ hit) : 1'b0;
    end
  end

  assign pwm_out = idle_lvl ^ (armed & (toggle_mode ? tog_q : pulse_q));

endmodule

// File: rtl/uptimer_pwm.sv
module uptimer_pwm
  import tmr_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr_en,
  input  logic [2:0]       reg_addr,
  input  logic [CNT_W-1:0] reg_wdata,
  output logic [CNT_W-1:0] reg_rdata,
  output logic             pwm_out,
  output logic             irq
);
  ctrl_t            ctrl_q;
  logic [CNT_W-1:0] load_q;
  logic [CNT_W-1:0] match_q;
  logic [CNT_W-1:0] cnt_q;
  logic [EV_N-1:0]  ien_q;
  logic [EV_N-1:0]  stat_q;
  logic [EV_N-1:0]  ev;
  logic             tick;
  logic             ovf_ev;
  logic             mat_ev;
  logic             wr_ctrl, wr_cnt, wr_load, wr_trig, wr_match, wr_ien, wr_stat;

  assign wr_ctrl  = reg_wr_en & (reg_addr == A_CTRL);
  assign wr_cnt   = reg_wr_en & (reg_addr == A_CNT);
  assign wr_load  = reg_wr_en & (reg_addr == A_LOAD);
  assign wr_trig  = reg_wr_en & (reg_addr == A_TRIG);
  assign wr_match = reg_wr_en & (reg_addr == A_MATCH);
  assign wr_ien   = reg_wr_en & (reg_addr == A_IEN);
  assign wr_stat  = reg_wr_en & (reg_addr == A_STAT);

  tmr_prescale #(.RATIO_W(RATIO_W)) u_pre (
    .clk    (clk),
    .rst_n  (rst_n),
    .run    (ctrl_q.run),
    .pre_en (ctrl_q.pre_en),
    .ratio  (ctrl_q.ratio),
    .tick   (tick)
  );

  tmr_core #(.CNT_W(CNT_W)) u_core (
    .clk          (clk),
    .rst_n        (rst_n),
    .tick         (tick),
    .autoreload   (ctrl_q.autoreload),
    .cmp_en       (ctrl_q.cmp_en),
    .load_val     (load_q),
    .match_val    (match_q),
    .host_cnt_we  (wr_cnt),
    .host_trig_we (wr_trig),
    .host_data    (reg_wdata),
    .cnt          (cnt_q),
    .ovf_ev       (ovf_ev),
    .mat_ev       (mat_ev)
  );

  tmr_pwm u_pwm (
    .clk         (clk),
    .rst_n       (rst_n),
    .idle_lvl    (ctrl_q.idle),
    .toggle_mode (ctrl_q.tgl),
    .src         (ctrl_q.src),
    .ovf_ev      (ovf_ev),
    .mat_ev      (mat_ev),
    .pwm_out     (pwm_out)
  );

  // Control: host write wins over the run-bit clear from a one-shot wrap.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
    end else if (wr_ctrl) begin
      ctrl_q <= ctrl_t'(reg_wdata[CTRL_W-1:0] & CTRL_MASK);
    end else if (ovf_ev && !ctrl_q.autoreload) begin
      ctrl_q.run <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      load_q  <= '0;
      match_q <= '0;
      ien_q   <= '0;
    end else begin
      if (wr_load)  load_q  <= reg_wdata;
      if (wr_match) match_q <= reg_wdata;
      if (wr_ien)   ien_q   <= reg_wdata[EV_N-1:0];
    end
  end

  always_comb begin
    ev           = '0;
    ev[EV_MATCH] = mat_ev;
    ev[EV_OVF]   = ovf_ev;
  end

  // Sticky flags, write-one-to-clear, a new event outranks the clear.
  for (genvar i = 0; i < EV_N; i++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        stat_q[i] <= 1'b0;
      end else begin
        stat_q[i] <= (stat_q[i] & ~(wr_stat & reg_wdata[i])) | ev[i];
      end
    end
  end

  assign irq = |(stat_q & ien_q);

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_CTRL:  reg_rdata = CNT_W'(ctrl_q);
      A_CNT:   reg_rdata = cnt_q;
      A_LOAD:  reg_rdata = load_q;
      A_MATCH: reg_rdata = match_q;
      A_IEN:   reg_rdata = CNT_W'(ien_q);
      A_STAT:  reg_rdata = CNT_W'(stat_q);
      default: reg_rdata = '0;
    endcase
  end

endmodule

// File: rtl/uptimer_pwm_chk.sv
module uptimer_pwm_chk
  import tmr_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input ctrl_t            ctrl,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] load,
  input logic [EV_N-1:0]  stat,
  input logic             tick,
  input logic             wr_en,
  input logic [2:0]       addr,
  input logic             wclr0,
  input logic             pwm_out
);
  logic host_cnt_touch;
  assign host_cnt_touch = wr_en & ((addr == A_CNT) | (addr == A_TRIG));

  assert_hold_stopped_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl.run && !host_cnt_touch) |=> $stable(cnt));

  assert_wrap_stop_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && (&cnt) && !ctrl.autoreload && !host_cnt_touch && !(wr_en && addr == A_CTRL))
      |=> (cnt == '0) && !ctrl.run && stat[EV_OVF]);

  assert_reload_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && (&cnt) && ctrl.autoreload && !host_cnt_touch) |=> (cnt == $past(load)));

  assert_trigger_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_TRIG) |=> (cnt == $past(load)));

  assert_flag_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (stat[EV_MATCH] && !(wr_en && addr == A_STAT && wclr0)) |=> stat[EV_MATCH]);

  assert_pwm_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl.src == 2'b00) |-> (pwm_out == ctrl.idle));

endmodule

bind uptimer_pwm uptimer_pwm_chk #(.CNT_W(CNT_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .ctrl    (ctrl_q),
  .cnt     (cnt_q),
  .load    (load_q),
  .stat    (stat_q),
  .tick    (tick),
  .wr_en   (reg_wr_en),
  .addr    (reg_addr),
  .wclr0   (reg_wdata[0]),
  .pwm_out (pwm_out)
);

// File: tb/uptimer_pwm_bench.sv
`timescale 1ns/1ps
module uptimer_pwm_bench;
  localparam int W = 32;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         reg_wr_en = 1'b0;
  logic [2:0]   reg_addr = 3'd0;
  logic [W-1:0] reg_wdata = '0;
  logic [W-1:0] reg_rdata;
  logic         pwm_out;
  logic         irq;

  always #2.5 clk = ~clk;

  uptimer_pwm #(.CNT_W(W)) u_uptimer_pwm (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr_en (reg_wr_en),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .pwm_out   (pwm_out),
    .irq       (irq)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // Reference model state (post-edge values)
  logic [W-1:0] m_cnt = '0, m_load = '0, m_match = '0;
  logic [12:0]  m_ctrl = '0;
  logic [1:0]   m_ien = '0, m_stat = '0;
  logic [7:0]   m_pre = '0;
  logic         m_pulse = 1'b0, m_tog = 1'b0;

  function automatic logic exp_pwm();
    logic armed;
    armed = |m_ctrl[11:10];
    return m_ctrl[7] ^ (armed & (m_ctrl[12] ? m_tog : m_pulse));
  endfunction

  function automatic logic exp_irq();
    return |(m_stat & m_ien);
  endfunction

  task automatic step(input bit w, input logic [2:0] a, input logic [W-1:0] d);
    logic [8:0] span;
    logic [7:0] last;
    logic tk, ovf, mat, sel, run, pre;
    logic [W-1:0] n_cnt, n_load, n_match;
    logic [12:0] n_ctrl;
    logic [1:0] n_ien, n_stat, clr;
    logic [7:0] n_pre;
    logic n_tog;
    reg_wr_en = w; reg_addr = a; reg_wdata = d;
    run  = m_ctrl[0];
    pre  = m_ctrl[5];
    span = 9'd1 << (m_ctrl[4:2] + 3'd1 + 4'd0);
    last = 8'(span - 9'd1);
    tk   = run && (!pre || m_pre == last);
    n_pre = (!run || !pre || m_pre == last) ? 8'd0 : m_pre + 8'd1;
    ovf  = tk && (m_cnt == '1);
    mat  = tk && m_ctrl[6] && (m_cnt == m_match);
    if (w && a == 3'd1)      n_cnt = d;
    else if (w && a == 3'd3) n_cnt = m_load;
    else if (tk)             n_cnt = ovf ? (m_ctrl[1] ? m_load : '0) : m_cnt + 1;
    else                     n_cnt = m_cnt;
    if (w && a == 3'd0)          n_ctrl = d[12:0] & 13'h1CFF;
    else if (ovf && !m_ctrl[1])  n_ctrl = m_ctrl & ~13'd1;
    else                         n_ctrl = m_ctrl;
    n_load  = (w && a == 3'd2) ? d : m_load;
    n_match = (w && a == 3'd4) ? d : m_match;
    n_ien   = (w && a == 3'd5) ? d[1:0] : m_ien;
    clr     = (w && a == 3'd6) ? d[1:0] : 2'b00;
    n_stat  = (m_stat & ~clr) | {ovf, mat};
    sel     = ((m_ctrl[11:10] != 2'b00) && ovf) || (m_ctrl[11] && mat);
    n_tog   = (m_ctrl[11:10] == 2'b00) ? 1'b0 : (m_tog ^ sel);
    @(posedge clk);
    m_cnt = n_cnt; m_load = n_load; m_match = n_match; m_ctrl = n_ctrl;
    m_ien = n_ien; m_stat = n_stat; m_pre = n_pre; m_pulse = sel; m_tog = n_tog;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1'b0, 3'd0, '0);
  endtask

  task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [2:0] a, output logic [W-1:0] v);
    reg_wr_en = 1'b0;
    reg_addr  = a;
    #0.1;
    v = reg_rdata;
  endtask

  task automatic chk_reg(input string tag, input logic [2:0] a, input logic [W-1:0] exp);
    logic [W-1:0] v;
    rd(a, v);
    chk(tag, v, exp);
  endtask

  task automatic chk_model();
    chk_reg("R2 counter vs model", 3'd1, m_cnt);
    chk_reg("R4 control vs model", 3'd0, W'(m_ctrl));
    chk_reg("R8 status vs model", 3'd6, W'(m_stat));
    chk("R11 pwm vs model", W'(pwm_out), W'(exp_pwm()));
    chk("R9 irq vs model", W'(irq), W'(exp_irq()));
  endtask

  initial begin : watchdog
    #(5.0 * 150000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin : main
    logic [W-1:0] d;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 / R13: reset state of every address
    for (int a = 0; a < 7; a++) chk_reg("R1 reset register", 3'(a), '0);
    chk("R1 reset pwm", W'(pwm_out), '0);
    chk("R1 reset irq", W'(irq), '0);

    // R13: register map readback
    step(1'b1, 3'd2, 32'hA5A5_0001);
    step(1'b1, 3'd4, 32'h0000_1234);
    step(1'b1, 3'd5, 32'hFFFF_FFFF);
    step(1'b1, 3'd0, 32'hFFFF_FF00);
    chk_reg("R13 load readback", 3'd2, 32'hA5A5_0001);
    chk_reg("R13 match readback", 3'd4, 32'h0000_1234);
    chk_reg("R13 ien width", 3'd5, 32'h3);
    chk_reg("R13 ctrl mask", 3'd0, 32'h1C00);
    chk_reg("R13 trigger reads zero", 3'd3, '0);
    step(1'b1, 3'd5, '0);
    step(1'b1, 3'd0, '0);

    // R2: run and stop
    step(1'b1, 3'd1, 32'd10);
    step(1'b1, 3'd0, 32'h1);
    idle(5);
    chk_reg("R2 counted five", 3'd1, 32'd15);
    step(1'b1, 3'd0, 32'h0);
    idle(3);
    chk_reg("R2 held while stopped", 3'd1, 32'd16);

    // R3: prescaler ratio 1 -> one tick per four clocks
    step(1'b1, 3'd1, 32'd0);
    step(1'b1, 3'd0, 32'h25);
    idle(8);
    chk_reg("R3 prescaled by four", 3'd1, 32'd2);
    step(1'b1, 3'd0, 32'h0);

    // R4: one-shot wrap
    step(1'b1, 3'd1, 32'hFFFF_FFFE);
    step(1'b1, 3'd0, 32'h1);
    idle(2);
    chk_reg("R4 wrapped to zero", 3'd1, 32'd0);
    chk_reg("R4 run cleared", 3'd0, 32'd0);
    chk_reg("R4 overflow flag", 3'd6, 32'd2);
    idle(2);
    chk_reg("R4 stays stopped", 3'd1, 32'd0);

    // R8: write-one-to-clear
    step(1'b1, 3'd6, 32'h1);
    chk_reg("R8 zero write keeps flag", 3'd6, 32'd2);
    step(1'b1, 3'd6, 32'h2);
    chk_reg("R8 one write clears flag", 3'd6, 32'd0);

    // R5: auto-reload
    step(1'b1, 3'd2, 32'd100);
    step(1'b1, 3'd1, 32'hFFFF_FFFF);
    step(1'b1, 3'd0, 32'h3);
    idle(1);
    chk_reg("R5 reloaded", 3'd1, 32'd100);
    chk_reg("R5 still running", 3'd0, 32'h3);
    chk_reg("R5 overflow flag", 3'd6, 32'd2);
    step(1'b1, 3'd0, 32'h0);
    step(1'b1, 3'd6, 32'h3);

    // R6: compare
    step(1'b1, 3'd1, 32'd50);
    step(1'b1, 3'd4, 32'd52);
    step(1'b1, 3'd0, 32'h41);
    idle(3);
    chk_reg("R6 match flag", 3'd6, 32'd1);
    step(1'b1, 3'd0, 32'h0);
    step(1'b1, 3'd6, 32'h3);
    step(1'b1, 3'd1, 32'd50);
    step(1'b1, 3'd0, 32'h1);
    idle(3);
    chk_reg("R6 no flag without compare", 3'd6, 32'd0);
    step(1'b1, 3'd0, 32'h0);

    // R9: interrupt masking
    step(1'b1, 3'd1, 32'd52);
    step(1'b1, 3'd0, 32'h41);
    idle(1);
    step(1'b1, 3'd0, 32'h0);
    chk("R9 no irq when disabled", W'(irq), '0);
    step(1'b1, 3'd5, 32'h2);
    chk("R9 other enable masked", W'(irq), '0);
    step(1'b1, 3'd5, 32'h1);
    chk("R9 irq on enabled flag", W'(irq), 32'd1);
    step(1'b1, 3'd6, 32'h1);
    chk("R9 irq drops after clear", W'(irq), '0);

    // R7: trigger and direct counter write
    step(1'b1, 3'd2, 32'd777);
    step(1'b1, 3'd3, 32'hDEAD);
    chk_reg("R7 trigger loads counter", 3'd1, 32'd777);
    step(1'b1, 3'd1, 32'd1234);
    chk_reg("R7 direct counter write", 3'd1, 32'd1234);

    // R10: idle level with no source
    step(1'b1, 3'd0, 32'h80);
    chk("R10 idle high", W'(pwm_out), 32'd1);
    step(1'b1, 3'd0, 32'h0);
    chk("R10 idle low", W'(pwm_out), 32'd0);

    // R11: pulse on overflow
    step(1'b1, 3'd2, 32'hFFFF_FFFE);
    step(1'b1, 3'd1, 32'hFFFF_FFFE);
    step(1'b1, 3'd0, 32'h403);
    idle(1);
    chk("R11 before event", W'(pwm_out), 32'd0);
    idle(1);
    chk("R11 pulse after overflow", W'(pwm_out), 32'd1);
    idle(1);
    chk("R11 pulse one cycle", W'(pwm_out), 32'd0);

    // R12: toggle on overflow
    step(1'b1, 3'd0, 32'h0);
    step(1'b1, 3'd1, 32'hFFFF_FFFE);
    step(1'b1, 3'd0, 32'h1403);
    idle(2);
    chk("R12 toggled on", W'(pwm_out), 32'd1);
    idle(1);
    chk("R12 held between events", W'(pwm_out), 32'd1);
    idle(1);
    chk("R12 toggled off", W'(pwm_out), 32'd0);

    // R10: source 11 behaves as overflow-or-match
    step(1'b1, 3'd0, 32'h0);
    step(1'b1, 3'd1, 32'd5);
    step(1'b1, 3'd4, 32'd6);
    step(1'b1, 3'd0, 32'hC41);
    idle(1);
    chk("R10 no pulse before match", W'(pwm_out), 32'd0);
    idle(1);
    chk("R10 match drives pwm", W'(pwm_out), 32'd1);
    chk_model();

    // Random phase against the reference model
    for (int n = 0; n < 3000; n++) begin
      int r;
      int a;
      r = int'($urandom % 16);
      if (r < 10) begin
        step(1'b0, 3'd0, '0);
      end else begin
        a = int'($urandom % 7);
        case (a)
          0: begin
            d = $urandom & 32'h1CFF;
            d[4:2] = 3'($urandom % 2);
            d[0] = (($urandom % 4) != 0);
          end
          1: d = 32'hFFFF_FFFF - ($urandom % 48);
          2: d = (($urandom % 2) != 0) ? 32'hFFFF_FFF0 + ($urandom % 16) : $urandom % 64;
          4: d = m_cnt + ($urandom % 8);
          default: d = $urandom;
        endcase
        step(1'b1, 3'(a), d);
      end
      chk_model();
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule